// File: doc/BRIEF.md
# Frame-Sync Power-Down Controller

This block decides whether the codec core is powered, using two sources of information: an active-low power-down input, and the presence of frame syncs. Everything runs on the master clock. The block powers down at once when the power-down input is low. It also powers down when the transmit and receive frame syncs both stay low for a long window while the bit clock keeps toggling. Wake-up needs the power-down input high and a rising edge on the transmit frame sync.

After wake-up the block raises a power-good level straight away. It keeps the serial transmit data pad disabled (high impedance) until a set number of further transmit frame syncs have arrived, so the converter path can settle before data leaves the chip. While the bit clock is idle, a lack of frame syncs is not taken as a power-down request. All asynchronous inputs pass through synchronizers before any edge or level is used.

Top module: `fs_pwr_ctrl`

## Requirements
- R1: While reset is asserted, and after reset is released with the power-down input low, `pwr_good` and `dout_en` are both 0.
- R2: From any state, a low level on `pdn_n` drives `pwr_good` and `dout_en` to 0 within 4 master-clock cycles.
- R3: With `pdn_n` high and the block powered down, the first rising edge of `fs_tx` sets `pwr_good` to 1 within 4 cycles, while `dout_en` stays 0.
- R4: After wake-up, `dout_en` stays 0 until `SETTLE_FS` (default 2) further rising edges of `fs_tx` have been seen. It becomes 1 within 4 cycles of the last of these edges.
- R5: While powered down, pulses on `fs_rx` alone never set `pwr_good`.
- R6: When `fs_tx` and `fs_rx` are both low for `SILENCE_CYC` master-clock cycles while `bclk_tx` toggles, `pwr_good` and `dout_en` fall to 0.
- R7: Pulses on `fs_rx` alone, arriving at least once per `SILENCE_CYC` cycles, keep a powered block powered.
- R8: Absent frame syncs never power the block down while `bclk_tx` has had no edge for `BCLK_WIN` cycles. The silence count holds while the bit clock is idle.
- R9: `dout_en` is 1 only while `pwr_good` is 1.
- R10: After a silence power-down with `pdn_n` still high, a returning `fs_tx` wakes the block again, and the settle sequence of R3 and R4 repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pdn_n | input | 1 | Asynchronous power-down request, active low |
| fs_tx | input | 1 | Transmit frame sync, asynchronous to `mclk` |
| fs_rx | input | 1 | Receive frame sync, asynchronous to `mclk` |
| bclk_tx | input | 1 | Transmit bit clock, sampled to detect activity |
| pwr_good | output | 1 | 1 while the codec core is powered |
| dout_en | output | 1 | Output enable of the transmit data pad; 0 means high impedance |

## Verification
The properties assume that every input level lasts at least one full master-clock cycle, so that the two-stage synchronizers capture every frame-sync pulse and every bit-clock phase. They also assume that valid frames repeat faster than the silence window. The bench changes all inputs on the falling edge of `mclk`. Frame-sync pulses are two cycles wide, the bit clock toggles every cycle, and the frame period is well inside `SILENCE_CYC`. A sweep over every combination of transmit sync, receive sync and bit-clock activity checks the resulting power state against the expected value: powered if any sync is present or the bit clock is idle.

// File: rtl/fs_pwr_pkg.sv
package fs_pwr_pkg;

  typedef enum logic [1:0] {
    PS_OFF     = 2'd0,
    PS_WAIT_FS = 2'd1,
    PS_SETTLE  = 2'd2,
    PS_ACTIVE  = 2'd3
  } pwr_state_e;

endpackage

// File: rtl/fs_pwr_sync.sv
module fs_pwr_sync #(
  parameter int                 WIDTH   = 1,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= RST_VAL;
        else        stage_q <= d;
      end
      assign q = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      logic [STAGES-1:0][WIDTH-1:0] chain_d;
      always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/fs_pwr_activity.sv
module fs_pwr_activity #(
  parameter int SILENCE_CYC = 1024,
  parameter int BCLK_WIN    = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_tx_s,
  input  logic fs_rx_s,
  input  logic bclk_s,
  output logic tx_rise,
  output logic bclk_alive,
  output logic silent
);

  localparam int SIL_W = $clog2(SILENCE_CYC + 1);
  localparam int GAP_W = $clog2(BCLK_WIN + 1);
  localparam logic [SIL_W-1:0] SIL_MAX = SIL_W'(SILENCE_CYC);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(BCLK_WIN);

  logic             tx_prev_q;
  logic             bclk_prev_q;
  logic             bclk_edge;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_en;
  logic [SIL_W-1:0] sil_q, sil_d;
  logic             sil_en;
  logic             any_fs;

  // edge history registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_prev_q   <= 1'b0;
      bclk_prev_q <= 1'b0;
    end else begin
      tx_prev_q   <= fs_tx_s;
      bclk_prev_q <= bclk_s;
    end
  end

  assign tx_rise   = fs_tx_s & ~tx_prev_q;
  assign bclk_edge = bclk_s ^ bclk_prev_q;
  assign any_fs    = fs_tx_s | fs_rx_s;

  // bit-clock gap counter: saturates at BCLK_WIN (clock idle)
  always_comb begin
    gap_en = 1'b0;
    gap_d  = gap_q;
    if (bclk_edge) begin
      gap_en = 1'b1;
      gap_d  = '0;
    end else if (gap_q != GAP_MAX) begin
      gap_en = 1'b1;
      gap_d  = gap_q + GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= GAP_MAX;
    else if (gap_en) gap_q <= gap_d;
  end

  assign bclk_alive = (gap_q != GAP_MAX);

  // frame-sync silence counter: advances only while the bit clock runs
  always_comb begin
    sil_en = 1'b0;
    sil_d  = sil_q;
    if (any_fs) begin
      sil_en = (sil_q != '0);
      sil_d  = '0;
    end else if (bclk_alive && (sil_q != SIL_MAX)) begin
      sil_en = 1'b1;
      sil_d  = sil_q + SIL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sil_q <= '0;
    else if (sil_en) sil_q <= sil_d;
  end

  assign silent = (sil_q == SIL_MAX);

endmodule

// File: rtl/fs_pwr_fsm.sv
module fs_pwr_fsm
  import fs_pwr_pkg::*;
#(
  parameter int SETTLE_FS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn_s,
  input  logic tx_rise,
  input  logic silent,
  output logic pwr_good,
  output logic dout_en
);

  localparam int CNT_W = (SETTLE_FS < 2) ? 1 : $clog2(SETTLE_FS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_FS - 1);

  pwr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             pg_d, de_d;

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_OFF: begin
        if (pdn_s) state_d = PS_WAIT_FS;
      end
      PS_WAIT_FS: begin
        if (!pdn_s)      state_d = PS_OFF;
        else if (tx_rise) state_d = PS_SETTLE;
      end
      PS_SETTLE: begin
        if (!pdn_s)                              state_d = PS_OFF;
        else if (silent)                         state_d = PS_WAIT_FS;
        else if (tx_rise && (cnt_q == CNT_LAST)) state_d = PS_ACTIVE;
      end
      PS_ACTIVE: begin
        if (!pdn_s)      state_d = PS_OFF;
        else if (silent) state_d = PS_WAIT_FS;
      end
      default: state_d = PS_OFF;
    endcase
  end

  // settle counter: counts transmit syncs while settling
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (state_q != PS_SETTLE) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tx_rise) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  assign pg_d = (state_d == PS_SETTLE) || (state_d == PS_ACTIVE);
  assign de_d = (state_d == PS_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_OFF;
      pwr_good <= 1'b0;
      dout_en  <= 1'b0;
    end else begin
      state_q  <= state_d;
      pwr_good <= pg_d;
      dout_en  <= de_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fs_pwr_ctrl.sv
module fs_pwr_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int SILENCE_CYC = 1024,
  parameter int BCLK_WIN    = 64,
  parameter int SETTLE_FS   = 2
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic pdn_n,
  input  logic fs_tx,
  input  logic fs_rx,
  input  logic bclk_tx,
  output logic pwr_good,
  output logic dout_en
);

  localparam int NUM_IN = 4;

  logic              rst_sync_n;
  logic [NUM_IN-1:0] raw_in, sync_in;
  logic              pdn_s, fs_tx_s, fs_rx_s, bclk_s;
  logic              tx_rise, bclk_alive, silent;

  // asynchronous assert, synchronous release
  fs_pwr_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (mclk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  assign raw_in = {pdn_n, fs_tx, fs_rx, bclk_tx};

  fs_pwr_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_in_sync (
    .clk   (mclk),
    .rst_n (rst_sync_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  assign {pdn_s, fs_tx_s, fs_rx_s, bclk_s} = sync_in;

  fs_pwr_activity #(.SILENCE_CYC(SILENCE_CYC), .BCLK_WIN(BCLK_WIN)) u_activity (
    .clk        (mclk),
    .rst_n      (rst_sync_n),
    .fs_tx_s    (fs_tx_s),
    .fs_rx_s    (fs_rx_s),
    .bclk_s     (bclk_s),
    .tx_rise    (tx_rise),
    .bclk_alive (bclk_alive),
    .silent     (silent)
  );

  fs_pwr_fsm #(.SETTLE_FS(SETTLE_FS)) u_fsm (
    .clk      (mclk),
    .rst_n    (rst_sync_n),
    .pdn_s    (pdn_s),
    .tx_rise  (tx_rise),
    .silent   (silent),
    .pwr_good (pwr_good),
    .dout_en  (dout_en)
  );

endmodule

// File: rtl/fs_pwr_ctrl_chk.sv
module fs_pwr_ctrl_chk (
  input logic mclk,
  input logic rst_sync_n,
  input logic pdn_s,
  input logic tx_rise,
  input logic silent,
  input logic bclk_alive,
  input logic pwr_good,
  input logic dout_en
);

  // R2
  pdn_forces_off_chk: assert property (@(posedge mclk) disable iff (!rst_sync_n)
    !pdn_s |=> (!pwr_good && !dout_en));

  // R3
  wake_on_tx_chk: assert property (@(posedge mclk) disable iff (!rst_sync_n)
    $rose(pwr_good) |-> ($past(tx_rise) && !dout_en));

  // R4
  enable_on_tx_chk: assert property (@(posedge mclk) disable iff (!rst_sync_n)
    $rose(dout_en) |-> ($past(tx_rise) && pwr_good));

  // R5
  stay_off_chk: assert property (@(posedge mclk) disable iff (!rst_sync_n)
    (!pwr_good && !tx_rise) |=> !pwr_good);

  // R6
  fall_cause_chk: assert property (@(posedge mclk) disable iff (!rst_sync_n)
    $fell(pwr_good) |-> $past(!pdn_s || silent));

  // R8
  idle_hold_chk: assert property (@(posedge mclk) disable iff (!rst_sync_n)
    (!bclk_alive && !silent) |=> !silent);

  // R9
  enable_needs_power_chk: assert property (@(posedge mclk) disable iff (!rst_sync_n)
    dout_en |-> pwr_good);

endmodule

bind fs_pwr_ctrl fs_pwr_ctrl_chk u_chk (
  .mclk       (mclk),
  .rst_sync_n (rst_sync_n),
  .pdn_s      (pdn_s),
  .tx_rise    (tx_rise),
  .silent     (silent),
  .bclk_alive (bclk_alive),
  .pwr_good   (pwr_good),
  .dout_en    (dout_en)
);

// File: tb/fs_pwr_ctrl_tb.sv
module fs_pwr_ctrl_tb;

  localparam int SIL   = 128;
  localparam int WIN   = 8;
  localparam int NFS   = 2;
  localparam int FRAME = 48;

  logic mclk = 1'b0;
  logic rst_n, pdn_n, fs_tx, fs_rx, bclk_tx;
  logic pwr_good, dout_en;
  logic tx_on, rx_on, bclk_on;
  int   nchk = 0;
  int   nfail = 0;
  bit   done = 1'b0;

  always #2.5 mclk = ~mclk;

  fs_pwr_ctrl #(.SYNC_STAGES(2), .SILENCE_CYC(SIL), .BCLK_WIN(WIN), .SETTLE_FS(NFS)) u_dut (
    .mclk     (mclk),
    .rst_n    (rst_n),
    .pdn_n    (pdn_n),
    .fs_tx    (fs_tx),
    .fs_rx    (fs_rx),
    .bclk_tx  (bclk_tx),
    .pwr_good (pwr_good),
    .dout_en  (dout_en)
  );

  // frame generator, driven on the falling edge
  initial begin
    int fcnt;
    fcnt = 0;
    fs_tx = 1'b0; fs_rx = 1'b0; bclk_tx = 1'b0;
    forever begin
      @(negedge mclk);
      fcnt = (fcnt == FRAME - 1) ? 0 : fcnt + 1;
      fs_tx = tx_on && (fcnt < 2);
      fs_rx = rx_on && (fcnt >= 10) && (fcnt < 12);
      if (bclk_on) bclk_tx = ~bclk_tx;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pdn_release();
    @(negedge fs_tx);
    @(negedge mclk);
    pdn_n = 1'b1;
  endtask

  task automatic bring_up(input string req);
    @(posedge fs_tx);
    wait_cyc(5);
    check({req, " R3 pwr_good after wake"}, pwr_good, 1'b1);
    check({req, " R3 dout_en after wake"}, dout_en, 1'b0);
    for (int i = 0; i < NFS; i++) begin
      @(posedge fs_tx);
      wait_cyc(5);
      check({req, " R4 dout_en during settle"}, dout_en, (i == NFS - 1));
      check({req, " R9 pwr_good while settling"}, pwr_good, 1'b1);
    end
  endtask

  task automatic power_cycle();
    tx_on = 1'b1; rx_on = 1'b0; bclk_on = 1'b1;
    pdn_n = 1'b0;
    wait_cyc(5);
    check("R2 pwr_good low", pwr_good, 1'b0);
    pdn_release();
    bring_up("cycle");
  endtask

  initial begin
    rst_n = 1'b0; pdn_n = 1'b0;
    tx_on = 1'b0; rx_on = 1'b0; bclk_on = 1'b1;
    wait_cyc(5);
    check("R1 pwr_good in reset", pwr_good, 1'b0);
    check("R1 dout_en in reset", dout_en, 1'b0);
    rst_n = 1'b1;
    wait_cyc(8);
    check("R1 pwr_good after reset", pwr_good, 1'b0);
    check("R1 dout_en after reset", dout_en, 1'b0);

    // R5: receive syncs alone never wake
    pdn_n = 1'b1; rx_on = 1'b1;
    wait_cyc(4 * FRAME);
    check("R5 pwr_good with rx only", pwr_good, 1'b0);
    rx_on = 1'b0; tx_on = 1'b1;
    bring_up("first");

    // R2 sweep: drop pdn_n after k transmit syncs since wake
    for (int k = 1; k <= NFS + 1; k++) begin
      tx_on = 1'b1; pdn_n = 1'b0;
      wait_cyc(5);
      pdn_release();
      for (int e = 0; e < k; e++) @(posedge fs_tx);
      wait_cyc(5);
      check("R2 pre-drop pwr_good", pwr_good, 1'b1);
      check("R2 pre-drop dout_en", dout_en, (k >= NFS + 1));
      pdn_n = 1'b0;
      wait_cyc(4);
      check("R2 pwr_good after drop", pwr_good, 1'b0);
      check("R2 dout_en after drop", dout_en, 1'b0);
    end

    // R6/R7/R8 sweep over tx, rx and bit-clock activity
    for (int p = 0; p < 8; p++) begin
      logic en_tx, en_rx, en_bclk, exp_pg;
      string tag;
      en_tx = p[0]; en_rx = p[1]; en_bclk = p[2];
      exp_pg = en_tx | en_rx | ~en_bclk;
      tag = !en_bclk ? "R8 idle bclk" : (!exp_pg ? "R6 silence" :
            (!en_tx ? "R7 rx keeps alive" : "R6 tx present"));
      power_cycle();
      @(negedge fs_tx);
      @(negedge mclk);
      tx_on = en_tx; rx_on = en_rx; bclk_on = en_bclk;
      wait_cyc(3 * SIL);
      check({tag, " pwr_good"}, pwr_good, exp_pg);
      check({tag, " dout_en"}, dout_en, exp_pg);
      if (!exp_pg) begin
        // R10: wake again after silence
        tx_on = 1'b1;
        bring_up("R10");
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mclk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule